// File: doc/BRIEF.md
# Dual Page-Buffer Serial Read Engine

This block is the target side of an SPI link. It answers sequential read commands aimed at two on-chip page buffers. Each transfer starts when chip select goes low. The host then sends:

- a one-byte command,
- three address bytes that carry the starting offset,
- one filler byte.

After that the block returns buffer bytes, most significant bit first, for as long as the host keeps clocking. When the read reaches the last location it starts again at offset zero of the same buffer. The transfer ends when chip select goes high.

A static mode input sets the buffer length to 528 or 512 bytes. The mode also sets how many of the 24 address bits form the offset. Two command codes point at each buffer, and the two codes for one buffer behave the same. A plain write port loads the buffers. The buffers are synchronous RAMs of the kind that map to block RAM.

The SPI pins are sampled by the fast system clock through a two-stage synchronizer. The link runs in mode 0: the host samples on the rising edge of SCK, and the block changes its output after each falling edge. The serial output has a driver-enable pin. When the enable is low, the line is treated as high impedance.

Top module: `dual_buf_reader`

## Requirements
- R1: Command 0xD4 and command 0xD1 both read buffer 0. Command 0xD6 and command 0xD3 both read buffer 1. The two codes that select a buffer give identical output.
- R2: With `page_512`=0, the start offset is bits 9..0 of the 24-bit address, which arrives most significant bit first. Bits 23..10 are ignored.
- R3: With `page_512`=1, the start offset is bits 8..0 of the address and bits 23..9 are ignored. The buffer length is then 512 bytes.
- R4: `spi_miso_oe` stays 0 while the command byte, the three address bytes and the single filler byte are shifted in. The first data bit is driven after the falling SCK edge that follows the eighth filler bit. Bytes go out most significant bit first.
- R5: After the last offset (527 with `page_512`=0, 511 with `page_512`=1), the next byte comes from offset 0 of the same buffer.
- R6: A rise of `spi_cs_n` ends the transfer at any bit. `spi_miso_oe` is 0 within 4 clock cycles after it.
- R7: With `page_512`=0, a start offset field of 528 or more is reduced by 528 before the first byte is read.
- R8: A command byte other than the four listed keeps `spi_miso_oe` at 0 until `spi_cs_n` goes high.
- R9: While `spi_cs_n` is high the engine returns to command capture, so the next low period starts a fresh command, even after an aborted transfer.
- R10: A clock cycle with `wr_en`=1 stores `wr_data` at offset `wr_addr` of the buffer chosen by `wr_buf` (0 or 1). Later reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 8 times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| page_512 | input | 1 | 1 = 512-byte buffers, 0 = 528-byte buffers; hold stable while `spi_cs_n` is low |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output driver enable for `spi_miso` (0 = high impedance) |
| wr_en | input | 1 | Buffer write strobe |
| wr_buf | input | 1 | Buffer selected for the write |
| wr_addr | input | 10 | Buffer offset for the write |
| wr_data | input | 8 | Byte to store |

## Verification
Most internal faults show up at the pins within one byte time of the data phase:

- A wrong bit count during the header moves every data bit, so the first returned byte is already wrong.
- A wrong command decode either raises the enable for an unknown code or reads the other buffer. Either is visible on the first data byte.
- A wrong wrap point or a wrong modulo reduction only appears at the buffer end or at a large start offset. Those cases are driven on purpose so the error shows on the byte that crosses the boundary.

A stale state after an abort shows up as a wrong first byte of the next transfer.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int DW        = 8;
  localparam int ADDR_BITS = 24;

  localparam logic [7:0] OPC_BUF0_A = 8'hD4;
  localparam logic [7:0] OPC_BUF0_B = 8'hD1;
  localparam logic [7:0] OPC_BUF1_A = 8'hD6;
  localparam logic [7:0] OPC_BUF1_B = 8'hD3;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_REJECT
  } dbr_state_t;
endpackage

// File: rtl/dbr_spi_front.sv
module dbr_spi_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic cs_active,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [SYNC-1:0] sck_sr, cs_sr, mosi_sr;
  logic            sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr  <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
      sck_d   <= 1'b0;
    end else begin
      sck_sr  <= {sck_sr[SYNC-2:0], sck_i};
      cs_sr   <= {cs_sr[SYNC-2:0], cs_n_i};
      mosi_sr <= {mosi_sr[SYNC-2:0], mosi_i};
      sck_d   <= sck_sr[SYNC-1];
    end
  end

  assign cs_active = ~cs_sr[SYNC-1];
  assign sck_rise  = sck_sr[SYNC-1] & ~sck_d;
  assign sck_fall  = ~sck_sr[SYNC-1] & sck_d;
  assign mosi_s    = mosi_sr[SYNC-1];
endmodule

// File: rtl/dbr_cmd_fsm.sv
module dbr_cmd_fsm
  import dbr_pkg::*;
#(
  parameter int LONG  = 528,
  parameter int SHORT = 512,
  localparam int AW   = $clog2(LONG),
  localparam int SAW  = $clog2(SHORT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_active,
  input  logic          sck_rise,
  input  logic          mosi_s,
  input  logic          page_512,
  output dbr_state_t    state,
  output logic          buf_sel,
  output logic [AW-1:0] start_off,
  output logic          start_load
);
  logic [4:0]    cnt;
  logic [7:0]    opc_sh;
  logic [7:0]    opc_next;
  logic [AW-1:0] off_sh;

  assign opc_next = {opc_sh[6:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      state      <= ST_OPC;
      cnt        <= '0;
      start_load <= 1'b0;
      if (rst) begin
        buf_sel <= 1'b0;
        opc_sh  <= '0;
        off_sh  <= '0;
      end
    end else begin
      start_load <= 1'b0;
      if (sck_rise) begin
        case (state)
          ST_OPC: begin
            opc_sh <= opc_next;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (opc_next == OPC_BUF0_A || opc_next == OPC_BUF0_B) begin
                buf_sel <= 1'b0;
                state   <= ST_ADDR;
              end else if (opc_next == OPC_BUF1_A || opc_next == OPC_BUF1_B) begin
                buf_sel <= 1'b1;
                state   <= ST_ADDR;
              end else begin
                state <= ST_REJECT;
              end
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_ADDR: begin
            off_sh <= {off_sh[AW-2:0], mosi_s};
            if (cnt == 5'(ADDR_BITS - 1)) begin
              cnt        <= '0;
              state      <= ST_DUMMY;
              start_load <= 1'b1;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_DUMMY: begin
            if (cnt == 5'd7) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (page_512)
      start_off = AW'(off_sh[SAW-1:0]);
    else if (off_sh >= AW'(LONG))
      start_off = off_sh - AW'(LONG);
    else
      start_off = off_sh;
  end

  // R9
  idle_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> state == ST_OPC);

  // R4
  dummy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMMY && cs_active) |-> cnt < 5'd8);
endmodule

// File: rtl/dbr_buf_ram.sv
module dbr_buf_ram #(
  parameter int DEPTH = 528,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbr_tx.sv
module dbr_tx
  import dbr_pkg::*;
#(
  parameter int LONG  = 528,
  parameter int SHORT = 512,
  localparam int AW   = $clog2(LONG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_active,
  input  logic          sck_fall,
  input  logic          in_data,
  input  logic          start_load,
  input  logic [AW-1:0] start_off,
  input  logic          page_512,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] rd_addr,
  output logic          miso,
  output logic          oe
);
  logic [2:0]    bcnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] last_off;

  assign last_off = page_512 ? AW'(SHORT - 1) : AW'(LONG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe      <= 1'b0;
      miso    <= 1'b0;
      bcnt    <= '0;
      sh      <= '0;
      rd_addr <= '0;
    end else if (!cs_active) begin
      oe   <= 1'b0;
      bcnt <= '0;
    end else begin
      if (start_load) rd_addr <= start_off;
      if (sck_fall && in_data) begin
        oe   <= 1'b1;
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd0) begin
          miso    <= rdata[DW-1];
          sh      <= {rdata[DW-2:0], 1'b0};
          rd_addr <= (rd_addr == last_off) ? '0 : rd_addr + AW'(1);
        end else begin
          miso <= sh[DW-1];
          sh   <= {sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  // R6
  deselect_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !oe);

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_data |-> rd_addr <= last_off);

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && in_data && sck_fall && bcnt == 3'd0 && rd_addr == last_off)
      |=> rd_addr == '0);
endmodule

// File: rtl/dual_buf_reader.sv
module dual_buf_reader
  import dbr_pkg::*;
#(
  parameter int LONG  = 528,
  parameter int SHORT = 512,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(LONG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          page_512,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          wr_en,
  input  logic          wr_buf,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic          cs_active, sck_rise, sck_fall, mosi_s;
  dbr_state_t    state;
  logic          buf_sel, start_load;
  logic [AW-1:0] start_off, rd_addr;
  logic [DW-1:0] rd_bank [2];
  logic [DW-1:0] rdata;

  dbr_spi_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .cs_active(cs_active), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  dbr_cmd_fsm #(.LONG(LONG), .SHORT(SHORT)) u_fsm (
    .clk(clk), .rst(rst), .cs_active(cs_active), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .page_512(page_512), .state(state), .buf_sel(buf_sel),
    .start_off(start_off), .start_load(start_load)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    dbr_buf_ram #(.DEPTH(LONG), .DW(DW)) u_ram (
      .clk(clk), .we(wr_en && (wr_buf == 1'(g))), .waddr(wr_addr),
      .wdata(wr_data), .raddr(rd_addr), .rdata(rd_bank[g])
    );
  end

  assign rdata = buf_sel ? rd_bank[1] : rd_bank[0];

  dbr_tx #(.LONG(LONG), .SHORT(SHORT)) u_tx (
    .clk(clk), .rst(rst), .cs_active(cs_active), .sck_fall(sck_fall),
    .in_data(state == ST_DATA), .start_load(start_load), .start_off(start_off),
    .page_512(page_512), .rdata(rdata), .rd_addr(rd_addr),
    .miso(spi_miso), .oe(spi_miso_oe)
  );

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_REJECT |-> !spi_miso_oe);

  // R4
  oe_only_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_miso_oe) |-> state == ST_DATA);
endmodule

// File: tb/tb_dual_buf_reader.sv
module tb_dual_buf_reader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       page_512 = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic       wr_en = 1'b0;
  logic       wr_buf = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [7:0] mdl [2][528];

  always #2 clk = ~clk;

  dual_buf_reader dut (
    .clk(clk), .rst(rst), .page_512(page_512), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_sck  = 1'b0;
      spi_mosi = tx[i];
      half();
      rx[i]  = spi_miso;
      oe_any = oe_any | spi_miso_oe;
      spi_sck = 1'b1;
      half();
    end
  endtask

  task automatic put(input logic b, input int a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_buf = b; wr_addr = 10'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    mdl[b][a] = d;
  endtask

  function automatic int start_of(input logic [23:0] a, input logic m);
    if (m) return int'(a[8:0]);
    if (a[9:0] >= 10'd528) return int'(a[9:0]) - 528;
    return int'(a[9:0]);
  endfunction

  task automatic finish_xfer(input string req);
    spi_sck = 1'b0;
    half();
    spi_cs_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(req, spi_miso_oe, 1'b0);
    half();
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a, output logic quiet);
    logic [7:0] r;
    logic o;
    quiet = 1'b1;
    spi_cs_n = 1'b0;
    half();
    xfer_byte(op, r, o);       quiet &= !o;
    xfer_byte(a[23:16], r, o); quiet &= !o;
    xfer_byte(a[15:8], r, o);  quiet &= !o;
    xfer_byte(a[7:0], r, o);   quiet &= !o;
    xfer_byte(8'hA5, r, o);    quiet &= !o;
  endtask

  task automatic read_run(input string req, input logic [7:0] op, input logic [23:0] a,
                          input logic m, input int n, input int abort_bits);
    logic quiet, o;
    logic [7:0] r;
    int idx;
    logic b;
    page_512 = m;
    b = (op == 8'hD6 || op == 8'hD3);
    header(op, a, quiet);
    chk({req, " R4 header quiet"}, quiet, 1'b1);
    idx = start_of(a, m);
    for (int k = 0; k < n; k++) begin
      xfer_byte(8'h00, r, o);
      chk(req, r, mdl[b][idx]);
      idx = (idx + 1) % (m ? 512 : 528);
    end
    for (int i = 0; i < abort_bits; i++) begin
      spi_sck = 1'b0; half(); spi_sck = 1'b1; half();
    end
    finish_xfer("R6");
  endtask

  initial begin
    logic quiet, o;
    logic [7:0] r;
    logic [7:0] ops [4];
    void'($urandom(32'h1D2E3F));
    ops[0] = 8'hD4; ops[1] = 8'hD1; ops[2] = 8'hD6; ops[3] = 8'hD3;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("reset R6", spi_miso_oe, 1'b0);

    for (int bb = 0; bb < 2; bb++)
      for (int a = 0; a < 528; a++) put(1'(bb), a, 8'($urandom));

    read_run("R1 D4", 8'hD4, 24'h000005, 1'b0, 6, 0);
    read_run("R1 D1", 8'hD1, 24'h000005, 1'b0, 6, 0);
    read_run("R1 D6", 8'hD6, 24'h000005, 1'b0, 6, 0);
    read_run("R1 D3", 8'hD3, 24'h000005, 1'b0, 6, 0);
    read_run("R2 ignored upper bits", 8'hD4, 24'hFFFC00 | 24'd200, 1'b0, 4, 0);
    read_run("R5 wrap 528", 8'hD6, 24'h00020D, 1'b0, 6, 0);
    read_run("R3 R5 wrap 512", 8'hD1, 24'hFFFFFD, 1'b1, 6, 0);
    read_run("R3 offset 512", 8'hD3, 24'h000280, 1'b1, 3, 0);
    read_run("R7 offset reduced", 8'hD4, 24'h0003E8, 1'b0, 3, 0);
    read_run("R7 max field", 8'hD3, 24'h0003FF, 1'b0, 3, 0);

    page_512 = 1'b0;
    spi_cs_n = 1'b0;
    half();
    quiet = 1'b1;
    xfer_byte(8'h0B, r, o); quiet &= !o;
    for (int i = 0; i < 8; i++) begin
      xfer_byte(8'h00, r, o); quiet &= !o;
    end
    chk("R8 unknown opcode quiet", quiet, 1'b1);
    finish_xfer("R6");

    read_run("R6 abort mid byte", 8'hD6, 24'h000010, 1'b0, 2, 3);
    read_run("R9 restart after abort", 8'hD4, 24'h000011, 1'b0, 3, 0);

    put(1'b1, 527, 8'h3C);
    put(1'b1, 0, 8'hC3);
    read_run("R10 write visible", 8'hD6, 24'h00020F, 1'b0, 2, 0);

    for (int t = 0; t < 8; t++) begin
      logic [23:0] a;
      logic m;
      a = 24'($urandom);
      m = 1'($urandom);
      read_run("R1 R5 random", ops[$urandom % 4], a, m, 1 + ($urandom % 12), 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule